// File: doc/BRIEF.md
# DDR Extended Mode Register with DLL Lock Guard

This block sits on the command path of a DDR SDRAM device model or memory controller. It watches a decoded command stream. When a mode-register-set command selects the extended register through the bank address, it captures three control bits: DLL off, reduced drive strength and the enable for the optional bus-isolation output. It keeps one activity bit per bank, so it can tell when every bank is idle, and it tracks whether the device is in self refresh.

A DLL enable can come from a register write or from leaving self refresh. After either one, the block runs two separate down-counters. The read counter holds reads back for the full lock time. The non-read counter holds every other command for a short time, and that time depends on the source of the enable. A command that arrives while its window is open, or that breaks a state rule, is dropped: it produces a one-cycle violation pulse on the cycle after issue. Every accepted command is passed on, registered, one cycle after issue.

Top module: `ddr_xmr_guard`

## Requirements
- R1: Out of reset, the three register bits read 0, the effective DLL output is 1, the non-read flag is 1, and the read flag stays 0 until the lock wait of RD_WAIT (200) cycles has run.
- R2: A mode-register-set command with ba = 2'b01 (BA0 high, BA1 low) loads addr[0] into DLL-off, addr[1] into reduced-drive and addr[2] into isolation-enable. A mode-register-set command with any other ba value leaves these bits unchanged but is still passed on.
- R3: An ACT sets the activity bit of its bank. A PRE clears the bank it addresses, or clears all banks when addr[10] = 1. An extended register write issued while any bank is active is dropped, raises a violation and leaves the register bits unchanged.
- R4: After a register write moves DLL-off from 1 to 0 (issued at edge T), a non-read command issued at T+1 is dropped with a violation, and one issued at T+2 is accepted.
- R5: After any DLL enable at edge T, a read issued at T+199 is dropped with a violation, and a read issued at T+200 is accepted. Each new enable reloads both counters.
- R6: An accepted self-refresh entry turns the effective DLL output off and lowers both flags. While in self refresh, every command other than NOP and self-refresh exit is dropped with a violation.
- R7: An accepted self-refresh exit, with DLL-off clear, re-enables the DLL. A non-read command issued at T+9 is dropped, and one issued at T+10 is accepted.
- R8: While DLL-off is set, reads need no lock wait. A self-refresh exit in this state starts no window, so reads and other commands are accepted at once.
- R9: Command codes are 0 NOP, 1 mode-register-set, 2 ACT, 3 PRE, 4 RD, 5 WR, 6 self-refresh entry, 7 self-refresh exit. A dropped command gives viol_o = 1 for one cycle, with fwd_vld_o = 0 and fwd_cmd_o = 0. An accepted command appears on fwd_cmd_o with fwd_vld_o = 1 one cycle after issue.
- R10: A self-refresh exit issued outside self refresh, or a self-refresh entry issued while any bank is active, is dropped with a violation.
- R11: An extended register write with addr[0] = 0 while the DLL is already enabled updates the other bits but does not restart either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ADDR_W | Address bits |
| dll_off_o | output | 1 | Stored DLL-off bit |
| drv_half_o | output | 1 | Stored reduced-drive bit |
| iso_en_o | output | 1 | Stored isolation-output enable |
| dll_on_o | output | 1 | Effective DLL state (off in self refresh) |
| rd_ok_o | output | 1 | A read issued now would be accepted |
| nrd_ok_o | output | 1 | A non-read command issued now would pass timing |
| viol_o | output | 1 | One-cycle pulse for a dropped command |
| fwd_vld_o | output | 1 | Forwarded command valid |
| fwd_cmd_o | output | 3 | Forwarded command code |
| fwd_ba_o | output | BA_W | Forwarded bank address |
| fwd_addr_o | output | ADDR_W | Forwarded address |

## Verification
The hardest case to reach is a read near the end of the lock window that follows a self-refresh exit. Getting there takes a chain of steps: banks must be precharged before entry is legal, the exit must find DLL-off clear, and the non-read window has to be crossed before the read window can be probed. The stimulus builds this chain in order and counts every edge between the exit and the probe reads. It places the blocked read exactly at T+199 and the accepted read at T+200. The debug path is reached through a separate chain: a write that sets DLL-off, then entry into and exit from self refresh.

// File: rtl/ddr_xmr_pkg.sv
package ddr_xmr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_MRS = 3'd1,
    CMD_ACT = 3'd2,
    CMD_PRE = 3'd3,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5,
    CMD_SRE = 3'd6,
    CMD_SRX = 3'd7
  } xmr_cmd_e;
endpackage

// File: rtl/xmr_bank_track.sv
module xmr_bank_track #(
  parameter int BA_W     = 2,
  parameter int ADDR_W   = 13,
  parameter int PALL_BIT = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  ddr_xmr_pkg::xmr_cmd_e cmd,
  input  logic [BA_W-1:0]       ba,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  all_idle
);
  import ddr_xmr_pkg::*;
  localparam int NBANK = 1 << BA_W;

  logic [NBANK-1:0] open_q;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit, set_b, clr_b, nxt, en;
      assign hit   = (ba == BA_W'(b));
      assign set_b = upd_en && (cmd == CMD_ACT) && hit;
      assign clr_b = upd_en && (cmd == CMD_PRE) && (hit || addr[PALL_BIT]);
      assign en    = set_b || clr_b;
      always_comb begin
        nxt = open_q[b];
        if (set_b)      nxt = 1'b1;
        else if (clr_b) nxt = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  open_q[b] <= 1'b0;
        else if (en) open_q[b] <= nxt;
      end
    end
  endgenerate

  assign all_idle = ~|open_q;

  assert_pall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && cmd == CMD_PRE && addr[PALL_BIT]) |=> all_idle);
endmodule

// File: rtl/xmr_window.sv
module xmr_window #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             open_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign open_o = (cnt_q != '0);
  assign cnt_en = load_i || open_o;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (open_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_window_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && open_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_window_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !open_o) |=> !open_o);
endmodule

// File: rtl/xmr_gate.sv
module xmr_gate (
  input  ddr_xmr_pkg::xmr_cmd_e cmd,
  input  logic                  is_ext,
  input  logic                  banks_idle,
  input  logic                  in_sr,
  input  logic                  rd_open,
  input  logic                  nrd_open,
  input  logic                  dll_off,
  output logic                  accept,
  output logic                  viol
);
  import ddr_xmr_pkg::*;
  logic blocked;

  always_comb begin
    blocked = 1'b0;
    if (in_sr) begin
      blocked = (cmd != CMD_SRX);
    end else begin
      unique case (cmd)
        CMD_NOP: blocked = 1'b0;
        CMD_SRX: blocked = 1'b1;
        CMD_RD:  blocked = rd_open && !dll_off;
        CMD_MRS: blocked = nrd_open || (is_ext && !banks_idle);
        CMD_SRE: blocked = nrd_open || !banks_idle;
        default: blocked = nrd_open;
      endcase
    end
  end

  assign accept = (cmd != CMD_NOP) && !blocked;
  assign viol   = (cmd != CMD_NOP) && blocked;
endmodule

// File: rtl/xmr_ext_reg.sv
module xmr_ext_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_bits,
  output logic       dll_off,
  output logic       drv_half,
  output logic       iso_en
);
  logic [2:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (wr_en) bits_d = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_q <= 3'b000;
    else if (wr_en) bits_q <= bits_d;
  end

  assign dll_off  = bits_q[0];
  assign drv_half = bits_q[1];
  assign iso_en   = bits_q[2];
endmodule

// File: rtl/ddr_xmr_guard.sv
module ddr_xmr_guard #(
  parameter int BA_W     = 2,
  parameter int ADDR_W   = 13,
  parameter int PALL_BIT = 10,
  parameter int RD_WAIT  = 200,
  parameter int MRD_WAIT = 2,
  parameter int SRX_WAIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              dll_off_o,
  output logic              drv_half_o,
  output logic              iso_en_o,
  output logic              dll_on_o,
  output logic              rd_ok_o,
  output logic              nrd_ok_o,
  output logic              viol_o,
  output logic              fwd_vld_o,
  output logic [2:0]        fwd_cmd_o,
  output logic [BA_W-1:0]   fwd_ba_o,
  output logic [ADDR_W-1:0] fwd_addr_o
);
  import ddr_xmr_pkg::*;
  localparam int              CNT_W  = $clog2(RD_WAIT + 1);
  localparam logic [BA_W-1:0] EXT_BA = BA_W'(1);

  xmr_cmd_e cmd_e;
  logic     is_ext, banks_idle, in_sr_q, in_sr_d;
  logic     rd_open, nrd_open, accept, viol;
  logic     ext_wr, mrs_en_evt, srx_evt, win_load;
  logic [CNT_W-1:0] nrd_val;

  assign cmd_e  = xmr_cmd_e'(cmd_i);
  assign is_ext = (ba_i == EXT_BA);

  xmr_bank_track #(.BA_W(BA_W), .ADDR_W(ADDR_W), .PALL_BIT(PALL_BIT)) u_banks (
    .clk(clk), .rst_n(rst_n), .upd_en(accept), .cmd(cmd_e),
    .ba(ba_i), .addr(addr_i), .all_idle(banks_idle)
  );

  xmr_gate u_gate (
    .cmd(cmd_e), .is_ext(is_ext), .banks_idle(banks_idle), .in_sr(in_sr_q),
    .rd_open(rd_open), .nrd_open(nrd_open), .dll_off(dll_off_o),
    .accept(accept), .viol(viol)
  );

  assign ext_wr     = accept && (cmd_e == CMD_MRS) && is_ext;
  assign mrs_en_evt = ext_wr && !addr_i[0] && dll_off_o;
  assign srx_evt    = accept && (cmd_e == CMD_SRX) && !dll_off_o;
  assign win_load   = mrs_en_evt || srx_evt;
  assign nrd_val    = srx_evt ? CNT_W'(SRX_WAIT - 1) : CNT_W'(MRD_WAIT - 1);

  xmr_ext_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(ext_wr), .wr_bits(addr_i[2:0]),
    .dll_off(dll_off_o), .drv_half(drv_half_o), .iso_en(iso_en_o)
  );

  xmr_window #(.CNT_W(CNT_W), .RST_VAL(RD_WAIT - 1)) u_rd_win (
    .clk(clk), .rst_n(rst_n), .load_i(win_load),
    .load_val_i(CNT_W'(RD_WAIT - 1)), .open_o(rd_open)
  );

  xmr_window #(.CNT_W(CNT_W), .RST_VAL(0)) u_nrd_win (
    .clk(clk), .rst_n(rst_n), .load_i(win_load),
    .load_val_i(nrd_val), .open_o(nrd_open)
  );

  // self-refresh state
  always_comb begin
    in_sr_d = in_sr_q;
    if (accept && cmd_e == CMD_SRE)      in_sr_d = 1'b1;
    else if (accept && cmd_e == CMD_SRX) in_sr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_sr_q <= 1'b0;
    else        in_sr_q <= in_sr_d;
  end

  assign dll_on_o = !in_sr_q && !dll_off_o;
  assign rd_ok_o  = !in_sr_q && (dll_off_o || !rd_open);
  assign nrd_ok_o = !in_sr_q && !nrd_open;

  // forwarding stage
  logic              vld_d, viol_d;
  logic [2:0]        fcmd_d;
  logic [BA_W-1:0]   fba_d;
  logic [ADDR_W-1:0] faddr_d;

  always_comb begin
    vld_d   = accept;
    viol_d  = viol;
    fcmd_d  = accept ? cmd_i : 3'd0;
    fba_d   = accept ? ba_i : '0;
    faddr_d = accept ? addr_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_vld_o  <= 1'b0;
      viol_o     <= 1'b0;
      fwd_cmd_o  <= 3'd0;
      fwd_ba_o   <= '0;
      fwd_addr_o <= '0;
    end else begin
      fwd_vld_o  <= vld_d;
      viol_o     <= viol_d;
      fwd_cmd_o  <= fcmd_d;
      fwd_ba_o   <= fba_d;
      fwd_addr_o <= faddr_d;
    end
  end

  assert_ext_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_e == CMD_MRS && is_ext && !banks_idle) |=> viol_o);
  assert_rd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_vld_o && fwd_cmd_o == 3'd4) |-> $past(rd_ok_o));
  assert_sr_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr_q && cmd_e inside {CMD_MRS, CMD_ACT, CMD_PRE, CMD_RD, CMD_WR}) |=> viol_o);
  assert_no_fwd_on_viol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> !fwd_vld_o);
  assert_sre_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sr_q) |-> $past(banks_idle));
endmodule

// File: tb/ddr_xmr_guard_bench.sv
`timescale 1ns/1ps
module ddr_xmr_guard_bench;
  localparam int BA_W = 2;
  localparam int ADDR_W = 13;
  localparam logic [2:0] NOP = 3'd0, MRS = 3'd1, ACT = 3'd2, PRE = 3'd3,
                         RD = 3'd4, WR = 3'd5, SRE = 3'd6, SRX = 3'd7;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cmd_i;
  logic [BA_W-1:0] ba_i;
  logic [ADDR_W-1:0] addr_i;
  logic dll_off_o, drv_half_o, iso_en_o, dll_on_o, rd_ok_o, nrd_ok_o;
  logic viol_o, fwd_vld_o;
  logic [2:0] fwd_cmd_o;
  logic [BA_W-1:0] fwd_ba_o;
  logic [ADDR_W-1:0] fwd_addr_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  ddr_xmr_guard u_ddr_xmr_guard (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ba_i(ba_i), .addr_i(addr_i),
    .dll_off_o(dll_off_o), .drv_half_o(drv_half_o), .iso_en_o(iso_en_o),
    .dll_on_o(dll_on_o), .rd_ok_o(rd_ok_o), .nrd_ok_o(nrd_ok_o),
    .viol_o(viol_o), .fwd_vld_o(fwd_vld_o), .fwd_cmd_o(fwd_cmd_o),
    .fwd_ba_o(fwd_ba_o), .fwd_addr_o(fwd_addr_o)
  );

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one command per cycle, expected result queued for the monitor
  task automatic issue(logic [2:0] c, logic [BA_W-1:0] b, logic [ADDR_W-1:0] a,
                       bit exp_viol, string tag);
    @(negedge clk);
    cmd_i = c; ba_i = b; addr_i = a;
    exp_q.push_back({exp_viol, !exp_viol && c != NOP, exp_viol ? NOP : c});
    tag_q.push_back(tag);
    @(posedge clk);
    #2;
    cmd_i = NOP; ba_i = '0; addr_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: compares registered results after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " viol"}, int'(viol_o), int'(e[4]));
      check({t, " fwd_vld"}, int'(fwd_vld_o), int'(e[3]));
      check({t, " fwd_cmd"}, int'(fwd_cmd_o), int'(e[2:0]));
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_i = NOP; ba_i = '0; addr_i = '0;
    #22;
    check("R1 dll_off", int'(dll_off_o), 0);
    check("R1 drv", int'(drv_half_o), 0);
    check("R1 iso", int'(iso_en_o), 0);
    check("R1 dll_on", int'(dll_on_o), 1);
    check("R1 rd_ok", int'(rd_ok_o), 0);
    check("R1 nrd_ok", int'(nrd_ok_o), 1);
    check("R1 viol", int'(viol_o), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(10);
    check("R1 rd_ok early", int'(rd_ok_o), 0);
    idle(195);
    check("R1 rd_ok after lock", int'(rd_ok_o), 1);
    issue(RD, 0, 0, 0, "R1 read after lock");

    // R11: enabled DLL rewritten with A0=0
    issue(MRS, 1, 13'h6, 0, "R11 ext write");
    check("R2 drv", int'(drv_half_o), 1);
    check("R2 iso", int'(iso_en_o), 1);
    check("R11 rd_ok kept", int'(rd_ok_o), 1);
    check("R11 nrd_ok kept", int'(nrd_ok_o), 1);
    issue(ACT, 0, 0, 0, "R11 act right after");
    issue(PRE, 0, 0, 0, "R11 pre");

    // R2: other bank addresses do not reach the extended register
    issue(MRS, 0, 13'h1, 0, "R2 base mrs fwd");
    check("R2 base no dll_off", int'(dll_off_o), 0);
    issue(MRS, 3, 13'h0, 0, "R2 ba3 mrs fwd");
    check("R2 ba3 drv kept", int'(drv_half_o), 1);

    // R3: write while a bank is open
    issue(ACT, 2, 0, 0, "R3 act bank2");
    issue(MRS, 1, 13'h7, 1, "R3 busy ext write");
    check("R3 dll_off unchanged", int'(dll_off_o), 0);
    issue(PRE, 2, 0, 0, "R3 pre bank2");
    issue(MRS, 1, 13'h7, 0, "R8 dll disable");
    check("R8 dll_off", int'(dll_off_o), 1);
    check("R8 dll_on", int'(dll_on_o), 0);
    check("R8 rd_ok debug", int'(rd_ok_o), 1);
    issue(RD, 0, 0, 0, "R8 debug read");

    // R4/R5: re-enable via register write at edge T
    issue(MRS, 1, 13'h6, 0, "R4 dll enable");
    check("R5 rd_ok closed", int'(rd_ok_o), 0);
    check("R4 nrd_ok closed", int'(nrd_ok_o), 0);
    issue(ACT, 0, 0, 1, "R4 act at T+1");
    issue(ACT, 0, 0, 0, "R4 act at T+2");
    issue(RD, 0, 0, 1, "R5 read at T+3");
    issue(PRE, 0, 13'h400, 0, "R3 precharge all");
    idle(194);
    issue(RD, 0, 0, 1, "R5 read at T+199");
    issue(RD, 0, 0, 0, "R5 read at T+200");

    // R10/R6/R7: self refresh
    issue(ACT, 1, 0, 0, "R10 act bank1");
    issue(SRE, 0, 0, 1, "R10 sre with open bank");
    issue(PRE, 1, 0, 0, "R10 pre bank1");
    issue(SRE, 0, 0, 0, "R6 sre");
    check("R6 dll_on", int'(dll_on_o), 0);
    check("R6 rd_ok", int'(rd_ok_o), 0);
    check("R6 nrd_ok", int'(nrd_ok_o), 0);
    issue(ACT, 0, 0, 1, "R6 act in sr");
    issue(RD, 0, 0, 1, "R6 read in sr");
    issue(SRX, 0, 0, 0, "R7 srx");
    check("R7 dll_on", int'(dll_on_o), 1);
    check("R7 nrd_ok closed", int'(nrd_ok_o), 0);
    issue(ACT, 0, 0, 1, "R7 act at T+1");
    idle(7);
    issue(ACT, 0, 0, 1, "R7 act at T+9");
    issue(ACT, 0, 0, 0, "R7 act at T+10");
    issue(PRE, 0, 13'h400, 0, "R7 pre all");
    idle(187);
    issue(RD, 0, 0, 1, "R5 srx read at T+199");
    issue(RD, 0, 0, 0, "R5 srx read at T+200");
    issue(SRX, 0, 0, 1, "R10 srx outside sr");

    // R8: self refresh with DLL disabled by register
    issue(MRS, 1, 13'h1, 0, "R8 disable again");
    issue(SRE, 0, 0, 0, "R8 sre");
    issue(SRX, 0, 0, 0, "R8 srx");
    check("R8 rd_ok after srx", int'(rd_ok_o), 1);
    check("R8 nrd_ok after srx", int'(nrd_ok_o), 1);
    issue(RD, 0, 0, 0, "R8 read after srx");
    issue(WR, 0, 0, 0, "R9 write fwd");
    idle(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule